// File: doc/BRIEF.md
# Interrupt-Sensing GPIO Bank

This block is a group of 32 general-purpose pins, organised as four ports of eight pins, placed behind a plain 32-bit register interface (address, write enable, write data, combinational read data). Software sets an output value and a per-pin output enable, and reads back both its own output value and the synchronized level seen on the pins.

Every pin can raise an interrupt. A three-bit trigger code, whose bits live at the same position in three separate sense registers, picks falling edge, rising edge, low level, high level or both edges. Each pin has an enable bit and a pending bit that software clears by writing one. A pin can also be filtered by one of three shared debounce timers, chosen by a two-bit code split over two registers. All pending and enabled pins are merged into one interrupt line.

Top module: `gpio_irq_bank`

## Requirements
- R1: Pin p of port k (k = 0..3, p = 0..7) occupies bit k*8+p of every per-pin register; the output value register at offset 0x00 drives pin_out and reads back what was written.
- R2: The direction register at offset 0x04 drives pin_oe; a bit of 1 makes that pin an output and 0 an input.
- R3: The read-only level register at offset 0x34 returns pin_in after a two-flop synchronizer.
- R4: A pin's trigger code takes bit 0 from the sense register at 0x0C, bit 1 from 0x10 and bit 2 from 0x14; code 0 triggers on a falling edge, 1 on a rising edge, 2 while low, 3 while high.
- R5: Trigger codes 4 to 7 trigger on both rising and falling edges.
- R6: The enable register at 0x08 gates each pin; a pin whose enable bit is 0 never shows a pending bit.
- R7: The pending register at 0x18 is cleared per bit by writing 1 and unchanged by writing 0; a level-triggered pin whose condition still holds is pending again on the cycle after the clear.
- R8: The debounce select of a pin takes bit 0 from register 0x20 and bit 1 from register 0x24; code 0 means the synchronized level is used directly.
- R9: With a debounce code of 1, 2 or 3, a new level is accepted only after it has stayed unchanged for at least one full period of the selected timer; shorter pulses are ignored.
- R10: Timers 1, 2 and 3 take 16-bit reload values at 0x28, 0x2C and 0x30 (readable back) and tick once every reload+1 cycles.
- R11: irq is high exactly when some pin has both its pending bit and its enable bit set.
- R12: Reset clears every register: all pins are inputs, all outputs low, interrupts disabled and irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| pin_in | input | 32 | Pin input levels |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables (1 = drive) |
| irq | output | 1 | Combined interrupt |

## Verification
Each trigger code is driven with a rising step, a falling step and a held level on its own pin, so that an edge code that behaved like a level code (or the reverse) shows up as a pending bit that does or does not return after a write-one clear. Both-edge behaviour is tried with codes 4 and 7 so that only the top code bit decides it, and a pin with its enable clear is toggled to show that the pending bit stays clear. Debounce is tried with a pulse shorter than the timer period, a level read back too early, and a level held long enough; a second run on a much slower timer proves that the select code, and not a fixed timer, sets the delay.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned PINS_PER_PORT  = 8;
  localparam int unsigned PORTS_PER_WORD = 4;
  localparam int unsigned WORD_W         = PINS_PER_PORT * PORTS_PER_WORD;
  localparam int unsigned N_TIMERS       = 3;
  localparam int unsigned ADDR_W         = 8;

  localparam logic [ADDR_W-1:0] OFS_OUT   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SNS0  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_SNS1  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SNS2  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_DSEL0 = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_DSEL1 = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_TMR1  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_TMR2  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_TMR3  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_LVL   = 8'h34;

  typedef enum logic [2:0] {
    TRIG_FALL = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_HIGH = 3'd3
  } trig_e;

  // Event for one pin given its trigger code, current and previous level.
  function automatic logic trig_hit(input logic [2:0] code, input logic cur, input logic prv);
    logic hit;
    if (code[2]) begin
      hit = cur ^ prv;
    end else begin
      case (trig_e'(code))
        TRIG_FALL: hit = prv & ~cur;
        TRIG_RISE: hit = cur & ~prv;
        TRIG_LOW:  hit = ~cur;
        default:   hit = cur;
      endcase
    end
    return hit;
  endfunction

endpackage

// File: rtl/gpio_tick_timer.sv
module gpio_tick_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == '0);

  always_comb begin
    if (tick_o) cnt_d = reload_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: after a tick the count restarts from the reload value
  assert_reload_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == $past(reload_i)));
  // R10: between ticks the count steps down by one
  assert_count_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter #(
  parameter int unsigned N_TICKS = 3,
  localparam int unsigned SEL_W  = $clog2(N_TICKS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [N_TICKS-1:0] ticks_i,
  output logic               sync_o,
  output logic               lvl_o
);

  logic meta_q, sync_q, sync_prev_q, armed_q, lvl_q;
  logic armed_d, lvl_d, tick_w;

  assign tick_w = (sel_i == '0) ? 1'b0 : ticks_i[sel_i - 1'b1];

  always_comb begin
    lvl_d   = lvl_q;
    armed_d = armed_q;
    if (sel_i == '0) begin
      lvl_d   = sync_q;
      armed_d = 1'b0;
    end else if ((sync_q == lvl_q) || (sync_q != sync_prev_q)) begin
      armed_d = 1'b0;
    end else if (tick_w) begin
      if (armed_q) begin
        lvl_d   = sync_q;
        armed_d = 1'b0;
      end else begin
        armed_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q      <= 1'b0;
      sync_q      <= 1'b0;
      sync_prev_q <= 1'b0;
      armed_q     <= 1'b0;
      lvl_q       <= 1'b0;
    end else begin
      meta_q      <= pin_i;
      sync_q      <= meta_q;
      sync_prev_q <= sync_q;
      armed_q     <= armed_d;
      lvl_q       <= lvl_d;
    end
  end

  assign sync_o = sync_q;
  assign lvl_o  = lvl_q;

  // R8: with no debounce the filtered level follows the synchronizer
  assert_bypass_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == '0) |=> (lvl_q == $past(sync_q)));
  // R9: a debounced level moves only on a tick of the selected timer
  assert_moves_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_i != '0) && !tick_w) |=> $stable(lvl_q));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] sns0_i,
  input  logic [N_PINS-1:0] sns1_i,
  input  logic [N_PINS-1:0] sns2_i,
  input  logic [N_PINS-1:0] en_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_PINS-1:0] pend_o
);

  logic [N_PINS-1:0] prev_q, pend_q, pend_d, hit;

  always_comb begin
    for (int i = 0; i < N_PINS; i++) begin
      hit[i] = trig_hit({sns2_i[i], sns1_i[i], sns0_i[i]}, lvl_i[i], prev_q[i]);
    end
    pend_d = (pend_q | (hit & en_i)) & ~clr_i & en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R6: no pin is pending unless it was enabled on the previous cycle
  assert_gated_by_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(en_i)) == '0));
  // R7: a write-one clear always empties the addressed bits
  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((pend_q & $past(clr_i)) == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned TMR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic [WORD_W-1:0] pin_in,
  output logic [WORD_W-1:0] pin_out,
  output logic [WORD_W-1:0] pin_oe,
  output logic              irq
);

  localparam int unsigned SEL_W = $clog2(N_TIMERS + 1);

  logic [WORD_W-1:0] out_q, dir_q, ien_q, sns0_q, sns1_q, sns2_q, dsel0_q, dsel1_q;
  logic [WORD_W-1:0] out_d, dir_d, ien_d, sns0_d, sns1_d, sns2_d, dsel0_d, dsel1_d;
  logic [TMR_W-1:0]  tmr_q [N_TIMERS];
  logic [TMR_W-1:0]  tmr_d [N_TIMERS];
  logic [N_TIMERS-1:0] ticks;
  logic [WORD_W-1:0] sync_lvl, filt_lvl, pend, clr;

  // Register next-state: a write replaces the addressed register
  always_comb begin
    out_d   = (wr_en && addr == OFS_OUT)   ? wdata : out_q;
    dir_d   = (wr_en && addr == OFS_DIR)   ? wdata : dir_q;
    ien_d   = (wr_en && addr == OFS_IEN)   ? wdata : ien_q;
    sns0_d  = (wr_en && addr == OFS_SNS0)  ? wdata : sns0_q;
    sns1_d  = (wr_en && addr == OFS_SNS1)  ? wdata : sns1_q;
    sns2_d  = (wr_en && addr == OFS_SNS2)  ? wdata : sns2_q;
    dsel0_d = (wr_en && addr == OFS_DSEL0) ? wdata : dsel0_q;
    dsel1_d = (wr_en && addr == OFS_DSEL1) ? wdata : dsel1_q;
    tmr_d[0] = (wr_en && addr == OFS_TMR1) ? wdata[TMR_W-1:0] : tmr_q[0];
    tmr_d[1] = (wr_en && addr == OFS_TMR2) ? wdata[TMR_W-1:0] : tmr_q[1];
    tmr_d[2] = (wr_en && addr == OFS_TMR3) ? wdata[TMR_W-1:0] : tmr_q[2];
    clr     = (wr_en && addr == OFS_PEND)  ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      sns0_q  <= '0;
      sns1_q  <= '0;
      sns2_q  <= '0;
      dsel0_q <= '0;
      dsel1_q <= '0;
      for (int t = 0; t < N_TIMERS; t++) tmr_q[t] <= '0;
    end else begin
      out_q   <= out_d;
      dir_q   <= dir_d;
      ien_q   <= ien_d;
      sns0_q  <= sns0_d;
      sns1_q  <= sns1_d;
      sns2_q  <= sns2_d;
      dsel0_q <= dsel0_d;
      dsel1_q <= dsel1_d;
      for (int t = 0; t < N_TIMERS; t++) tmr_q[t] <= tmr_d[t];
    end
  end

  // Shared debounce timers
  for (genvar t = 0; t < N_TIMERS; t++) begin : g_tmr
    gpio_tick_timer #(.CNT_W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload_i (tmr_q[t]),
      .tick_o   (ticks[t])
    );
  end

  // Per-pin synchronizer and debounce filter
  for (genvar p = 0; p < WORD_W; p++) begin : g_pin
    gpio_pin_filter #(.N_TICKS(N_TIMERS)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pin_in[p]),
      .sel_i   (SEL_W'({dsel1_q[p], dsel0_q[p]})),
      .ticks_i (ticks),
      .sync_o  (sync_lvl[p]),
      .lvl_o   (filt_lvl[p])
    );
  end

  gpio_irq_detect #(.N_PINS(WORD_W)) u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (filt_lvl),
    .sns0_i (sns0_q),
    .sns1_i (sns1_q),
    .sns2_i (sns2_q),
    .en_i   (ien_q),
    .clr_i  (clr),
    .pend_o (pend)
  );

  always_comb begin
    case (addr)
      OFS_OUT:   rdata = out_q;
      OFS_DIR:   rdata = dir_q;
      OFS_IEN:   rdata = ien_q;
      OFS_SNS0:  rdata = sns0_q;
      OFS_SNS1:  rdata = sns1_q;
      OFS_SNS2:  rdata = sns2_q;
      OFS_PEND:  rdata = pend;
      OFS_DSEL0: rdata = dsel0_q;
      OFS_DSEL1: rdata = dsel1_q;
      OFS_TMR1:  rdata = WORD_W'(tmr_q[0]);
      OFS_TMR2:  rdata = WORD_W'(tmr_q[1]);
      OFS_TMR3:  rdata = WORD_W'(tmr_q[2]);
      OFS_LVL:   rdata = sync_lvl;
      default:   rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(pend & ien_q);

  // R2: a direction write reaches pin_oe on the next cycle
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DIR) |=> (pin_oe == $past(wdata)));
  // R1: an output write reaches pin_out on the next cycle
  assert_out_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_OUT) |=> (pin_out == $past(wdata)));
  // R11: the interrupt line never rises without a pending bit
  assert_irq_needs_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0));

endmodule

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr_en;
  logic [31:0] wdata, rdata, pin_in, pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic mon_req = 1'b0;

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 pin_oe, 3 pin_out
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk;

  gpio_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Monitor: compares each observation with the oldest expected item
  always @(negedge clk) begin
    if (mon_req && exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = {31'b0, irq};
        2: act = pin_oe;
        default: act = pin_out;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int kind, input logic [7:0] a, input logic [31:0] e,
                            input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    @(posedge clk); #1;
    addr = a;
    exp_q.push_back(it);
    mon_req = 1'b1;
    @(negedge clk); #1;
    mon_req = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    idle(200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0; pin_in = '0;
    idle(3); #1 rst_n = 1'b1;

    // R12: reset state
    expect_val(0, 8'h00, 32'h0, "R12 out");
    expect_val(0, 8'h04, 32'h0, "R12 dir");
    expect_val(0, 8'h08, 32'h0, "R12 enable");
    expect_val(0, 8'h18, 32'h0, "R12 pending");
    expect_val(0, 8'h28, 32'h0, "R12 timer1");
    expect_val(2, 8'h00, 32'h0, "R12 pin_oe");
    expect_val(1, 8'h00, 32'h0, "R12 irq");

    // R1: port 2 pin 5 is bit 21; port 3 pin 7 is bit 31
    wr(8'h00, (32'h1 << (2*8+5)) | (32'h1 << (3*8+7)));
    expect_val(3, 8'h00, 32'h8020_0000, "R1 pin_out");
    expect_val(0, 8'h00, 32'h8020_0000, "R1 readback");
    // R2: direction
    wr(8'h04, 32'h00FF_0F01);
    expect_val(2, 8'h00, 32'h00FF_0F01, "R2 pin_oe");
    expect_val(0, 8'h04, 32'h00FF_0F01, "R2 readback");

    // R3: synchronized level
    pin_in = 32'hA5C3_0F11;
    idle(4);
    expect_val(0, 8'h34, 32'hA5C3_0F11, "R3 level");
    pin_in = '0;
    idle(4);
    expect_val(0, 8'h34, 32'h0, "R3 level low");

    // R4: rising edge, code 1, pin 9
    wr(8'h08, 32'h1 << 9);
    wr(8'h0C, 32'h1 << 9);
    pin_in[9] = 1'b1; idle(6);
    expect_val(0, 8'h18, 32'h0000_0200, "R4 rise");
    expect_val(1, 8'h00, 32'h1, "R11 irq set");
    wr(8'h18, 32'h0);
    expect_val(0, 8'h18, 32'h0000_0200, "R7 write zero");
    wr(8'h18, 32'h1 << 9);
    expect_val(0, 8'h18, 32'h0, "R7 clear edge");
    expect_val(1, 8'h00, 32'h0, "R11 irq clear");
    // R4: falling edge, code 0
    wr(8'h0C, 32'h0);
    pin_in[9] = 1'b0; idle(6);
    expect_val(0, 8'h18, 32'h0000_0200, "R4 fall");
    wr(8'h18, 32'h1 << 9);

    // R4/R7: high level, code 3, pin 20
    wr(8'h08, 32'h1 << 20);
    wr(8'h0C, 32'h1 << 20);
    wr(8'h10, 32'h1 << 20);
    pin_in[20] = 1'b1; idle(6);
    wr(8'h18, 32'h1 << 20);
    expect_val(0, 8'h18, 32'h0010_0000, "R7 level re-sets");
    pin_in[20] = 1'b0; idle(6);
    wr(8'h18, 32'h1 << 20);
    expect_val(0, 8'h18, 32'h0, "R4 high released");
    // R4: low level, code 2
    wr(8'h0C, 32'h0);
    idle(4);
    expect_val(0, 8'h18, 32'h0010_0000, "R4 low");
    pin_in[20] = 1'b1; idle(6);
    wr(8'h18, 32'h1 << 20);
    expect_val(0, 8'h18, 32'h0, "R4 low released");

    // R5: both edges with code 4, pin 27
    wr(8'h08, 32'h1 << 27);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h1 << 27);
    pin_in[27] = 1'b1; idle(6);
    expect_val(0, 8'h18, 32'h0800_0000, "R5 code4 rise");
    wr(8'h18, 32'h1 << 27);
    pin_in[27] = 1'b0; idle(6);
    expect_val(0, 8'h18, 32'h0800_0000, "R5 code4 fall");
    wr(8'h18, 32'h1 << 27);
    // R5: code 7
    wr(8'h0C, 32'h1 << 27);
    wr(8'h10, 32'h1 << 27);
    pin_in[27] = 1'b1; idle(6);
    expect_val(0, 8'h18, 32'h0800_0000, "R5 code7 rise");
    wr(8'h18, 32'h1 << 27);
    expect_val(0, 8'h18, 32'h0, "R5 code7 not level");
    pin_in[27] = 1'b0; idle(6);
    expect_val(0, 8'h18, 32'h0800_0000, "R5 code7 fall");
    wr(8'h18, 32'h1 << 27);

    // R6: disabled pin never pending
    wr(8'h08, 32'h0);
    pin_in[27] = 1'b1; idle(6);
    expect_val(0, 8'h18, 32'h0, "R6 disabled pending");
    expect_val(1, 8'h00, 32'h0, "R6 disabled irq");
    pin_in[27] = 1'b0; idle(6);

    // R9/R10: debounce on pin 3 with timer 1 (period 20), rising edge
    wr(8'h0C, 32'h1 << 3);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h28, 32'd19);
    expect_val(0, 8'h28, 32'd19, "R10 reload readback");
    wr(8'h20, 32'h1 << 3);
    wr(8'h08, 32'h1 << 3);
    pin_in[3] = 1'b1; idle(10); pin_in[3] = 1'b0;
    idle(60);
    expect_val(0, 8'h18, 32'h0, "R9 short pulse ignored");
    pin_in[3] = 1'b1; idle(12);
    expect_val(0, 8'h18, 32'h0, "R9 not before a period");
    idle(60);
    expect_val(0, 8'h18, 32'h0000_0008, "R9 accepted");
    wr(8'h18, 32'h1 << 3);
    pin_in[3] = 1'b0; idle(60);

    // R8/R10: code 2 selects timer 2 (period 200)
    wr(8'h2C, 32'd199);
    wr(8'h20, 32'h0);
    wr(8'h24, 32'h1 << 3);
    wr(8'h18, 32'h1 << 3);
    pin_in[3] = 1'b1; idle(120);
    expect_val(0, 8'h18, 32'h0, "R8 slow timer not yet");
    idle(400);
    expect_val(0, 8'h18, 32'h0000_0008, "R8 slow timer accepted");
    expect_val(1, 8'h00, 32'h1, "R11 irq debounced");

    finish_run();
  end

endmodule